// File: doc/BRIEF.md
# Shared-Operator Coupled Recurrence Engine

This block turns a stream of 16-bit samples x into three coupled sequences y, w and z. Each value comes from a unary halving operator (arithmetic shift right by one) and a commutative binary operator (wrap-around addition). The recurrences are y[n] = x[n] + w[n-2], w[n] = half(w[n-2]) + half(z[n-2]) and z[n] = half(y[n]) + half(w[n]). There is exactly one halving unit and one adder in the datapath, and both are reused on every clock cycle. A four-phase schedule assigns each unit's operands in each phase. Every operator result is written to a register before it is used again, so no cycle runs through more than one operator.

The two halvings that feed w[n+1] depend only on history that is already known. The schedule therefore computes them during the frame of sample n. Each frame needs four halvings and three additions, and it fits in four clock cycles. With a clock four times the sample rate, the block accepts one sample per input period. A sample is taken when in_valid is high while the block is idle. The three results are then reported together with a one-cycle done pulse.

Top module: `recur_tmux`

## Requirements
- R1: During and directly after reset, out_y, out_w and out_z are zero and out_done is low. All history terms start at zero, so the first sample gives y = x, w = 0 and z = half(x).
- R2: For every accepted sample, out_y equals (x[n] + w[n-2]) mod 2^16.
- R3: For every accepted sample, out_w equals (half(w[n-2]) + half(z[n-2])) mod 2^16.
- R4: For every accepted sample, out_z equals (half(y[n]) + half(w[n])) mod 2^16, using the y and w of that same sample.
- R5: half(v) is a two's-complement arithmetic shift right by one. Bit 15 is copied into the vacated top bit, so negative values stay negative.
- R6: out_done is high for exactly one cycle. It rises on the fourth rising clock edge counted from, and including, the edge that accepts the sample.
- R7: A sample is accepted only in the idle phase. in_valid during the three busy cycles that follow an acceptance is ignored: it starts no frame, changes no result and shifts no history.
- R8: If in_valid is held high, a new sample is accepted on the edge right after each done pulse appears, which gives one result every 4 cycles.
- R9: While the block is idle and in_valid is low, out_y, out_w and out_z hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, four cycles per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, taken only when idle |
| in_x | input | 16 | Input sample x[n] |
| out_y | output | 16 | Result y[n] |
| out_w | output | 16 | Result w[n] |
| out_z | output | 16 | Result z[n] |
| out_done | output | 1 | One-cycle pulse when y, w and z of a sample are valid |

## Verification
The done-pulse and phase-order properties assume that in_valid is only ever acted on in the idle phase. The bench holds in_valid high on purpose through busy cycles, to confirm that it is ignored there. The output-hold property assumes no sample arrives while the block is idle. The bench therefore checks stability only in idle stretches with in_valid low. History is expected to move only at the end of a frame. Junk samples offered mid-frame must not appear in the bench's reference sequence, which is built only from samples that were accepted.

// File: rtl/recur_pkg.sv
package recur_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_1    = 2'd1,
        PH_2    = 2'd2,
        PH_3    = 2'd3
    } phase_t;

endpackage

// File: rtl/recur_op1.sv
// Unary operator: two's-complement halving by arithmetic shift.
module recur_op1 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] r
);
    always_comb begin
        r = {a[W-1], a[W-1:1]};
    end
endmodule

// File: rtl/recur_op2.sv
// Commutative binary operator: wrap-around addition.
module recur_op2 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    always_comb begin
        r = a + b;
    end
endmodule

// File: rtl/recur_seq.sv
// Four-phase frame sequencer: idle waits for start, then three busy phases.
module recur_seq
    import recur_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase
);
    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (start) ph_d = PH_1;
            PH_1:    ph_d = PH_2;
            PH_2:    ph_d = PH_3;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;

    AST_BUSY_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_1) |=> (ph_q == PH_2)); // R7
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_3) |=> (ph_q == PH_IDLE)); // R8
    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && !start) |=> (ph_q == PH_IDLE)); // R7
endmodule

// File: rtl/recur_tmux.sv
// Coupled recurrence engine with one shared halving unit and one shared adder.
module recur_tmux
    import recur_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_x,
    output logic [W-1:0] out_y,
    output logic [W-1:0] out_w,
    output logic [W-1:0] out_z,
    output logic         out_done
);
    typedef struct packed {
        logic [W-1:0] x;    // latched sample
        logic [W-1:0] pa;   // half(w) prepared for next sample
        logic [W-1:0] pb;   // half(z) prepared for next sample
        logic [W-1:0] hw;   // half(w[n]) of current frame
        logic [W-1:0] hy;   // half(y[n]) of current frame
        logic [W-1:0] y;
        logic [W-1:0] w;
        logic [W-1:0] z;
        logic [W-1:0] w1;   // w one sample back
        logic [W-1:0] w2;   // w two samples back
        logic [W-1:0] z1;   // z one sample back
        logic         done;
    } dp_t;

    dp_t    s_d, s_q;
    phase_t phase;
    logic   accept;
    logic [W-1:0] op1_a, op1_r;
    logic [W-1:0] op2_a, op2_b, op2_r;

    assign accept = (phase == PH_IDLE) && in_valid;

    recur_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .phase (phase)
    );

    recur_op1 #(.W(W)) u_op1 (.a(op1_a), .r(op1_r));
    recur_op2 #(.W(W)) u_op2 (.a(op2_a), .b(op2_b), .r(op2_r));

    // Operand steering for the shared operators.
    always_comb begin
        op1_a = '0;
        op2_a = '0;
        op2_b = '0;
        case (phase)
            PH_IDLE: begin
                op1_a = s_q.w1;
                op2_a = s_q.pa;
                op2_b = s_q.pb;
            end
            PH_1: begin
                op1_a = s_q.w;
                op2_a = s_q.x;
                op2_b = s_q.w2;
            end
            PH_2: begin
                op1_a = s_q.y;
            end
            default: begin
                op1_a = s_q.z1;
                op2_a = s_q.hw;
                op2_b = s_q.hy;
            end
        endcase
    end

    // Next-state computation.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.x  = in_x;
                    s_d.w  = op2_r;
                    s_d.pa = op1_r;
                end
            end
            PH_1: begin
                s_d.y  = op2_r;
                s_d.hw = op1_r;
            end
            PH_2: begin
                s_d.hy = op1_r;
            end
            default: begin
                s_d.z    = op2_r;
                s_d.pb   = op1_r;
                s_d.w2   = s_q.w1;
                s_d.w1   = s_q.w;
                s_d.z1   = op2_r;
                s_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_y    = s_q.y;
    assign out_w    = s_q.w;
    assign out_z    = s_q.z;
    assign out_done = s_q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done); // R6
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_3) |=> out_done); // R6
    AST_HIST_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_3) |=> ($stable(s_q.w1) && $stable(s_q.z1))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !in_valid) |=>
            ($stable(out_y) && $stable(out_w) && $stable(out_z))); // R9
endmodule

// File: tb/recur_tmux_test.sv
module recur_tmux_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_x = '0;
    logic [W-1:0] out_y, out_w, out_z;
    logic         out_done;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference history, kept in the bench.
    logic [W-1:0] mw1 = '0, mw2 = '0, mz1 = '0, mz2 = '0;
    logic [W-1:0] ey, ew, ez;

    always #4 clk = ~clk;

    recur_tmux #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_y(out_y), .out_w(out_w), .out_z(out_z), .out_done(out_done)
    );

    function automatic logic [W-1:0] half(input logic [W-1:0] v);
        logic signed [W-1:0] s;
        s = v;
        return W'(s >>> 1);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Advance the reference model by one accepted sample.
    task automatic model_step(input logic [W-1:0] x);
        ey = x + mw2;
        ew = half(mw2) + half(mz2);
        ez = half(ey) + half(ew);
        mw2 = mw1; mw1 = ew;
        mz2 = mz1; mz1 = ez;
    endtask

    task automatic check_results();
        check("R2 y", out_y, ey);
        check("R3 w", out_w, ew);
        check("R4 z", out_z, ez);
        if (ey[W-1]) check("R5 negative halving", out_z, ez);
    endtask

    // One isolated sample; optionally offer junk during the busy cycles.
    task automatic run_one(input logic [W-1:0] x, input bit junk);
        @(negedge clk);
        in_valid = 1'b1; in_x = x;
        model_step(x);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i < 4) begin
                check("R6 done early", {15'd0, out_done}, 16'd0);
                in_valid = junk;
                in_x = ~x ^ W'(i);
            end else begin
                check("R6 done on fourth edge", {15'd0, out_done}, 16'd1);
                in_valid = 1'b0;
            end
        end
        check_results();
        @(negedge clk);
        check("R6 done single cycle", {15'd0, out_done}, 16'd0);
        if (junk) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check("R7 no frame from junk", {15'd0, out_done}, 16'd0);
                check("R9 y held", out_y, ey);
                check("R9 z held", out_z, ez);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [W-1:0] vals [8];
        int since;
        vals = '{16'h1234, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'hC3A5, 16'h0000, 16'h5A5A};

        repeat (3) @(negedge clk);
        check("R1 y reset", out_y, '0);
        check("R1 w reset", out_w, '0);
        check("R1 z reset", out_z, '0);
        check("R1 done reset", {15'd0, out_done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {15'd0, out_done}, 16'd0);

        // First sample with zero history: y = x, w = 0, z = half(x).
        run_one(16'h9876, 1'b0);
        check("R1 first y", out_y, 16'h9876);
        check("R1 first w", out_w, 16'h0000);
        check("R5 first z sign", out_z, 16'hCC3B);

        foreach (vals[i]) run_one(vals[i], i[0]);

        for (int i = 0; i < 300; i++)
            run_one(W'(i * 40503 + 7919), (i % 3) == 0);

        // Back-to-back stream with in_valid held high.
        @(negedge clk);
        in_valid = 1'b1;
        in_x = 16'h0F0F;
        for (int k = 0; k < 40; k++) begin
            model_step(in_x);
            since = 0;
            do begin
                @(negedge clk);
                since++;
            end while (!out_done && since < 10);
            check("R8 four cycles per sample", W'(since), 16'd4);
            check_results();
            in_x = W'(k * 9176 + 333);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 done drops", {15'd0, out_done}, 16'd0);
        repeat (2) @(negedge clk);
        check("R9 w held idle", out_w, ew);

        finish_run();
    end
endmodule